// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers level-sensitive interrupt requests from a primary group of sources (40 by default) and a secondary group (32 by default). The secondary group does not reach the CPU directly. Its enabled, pending sources are OR-ed together and fed into primary source 0. One request line goes to the CPU. Software reads a priority index register to find the lowest-numbered active primary source. When that register returns 0, software reads the secondary status register and scans it upward from bit 0.

Every source has a pending bit, which is cleared by writing a 1 to it, and an enable bit. An enable bit is set through one address and cleared through another, and bits written as 0 change nothing. The primary per-source registers are split into 32-bit banks, one word apart. The register bus is a single-cycle word bus with byte addresses: a write is taken on the clock edge and a read is combinational. A table of per-source channel mapping words, one per primary source, starts at 0x200.

Top module: `cascade_intc`

## Requirements
- R1: The primary per-source registers use two banks. Bank 0 (sources 0..31) is at the base offset and bank 1 (sources 32..39) is at base + 0x4. Bank 1 implements only bits 7:0 and reads zero above them.
- R2: A 1 written to a bit at 0x20/0x24 enables that primary source. A 1 written at 0x30/0x34 disables it. Bits written as 0 leave the enable unchanged. Reads of 0x20/0x24 and 0x30/0x34 return the enable mask. The secondary group behaves the same way at 0x90 (set) and 0x98 (clear), and both of those addresses read back the secondary enable mask.
- R3: A 1 written at 0x10/0x14 clears the matching primary pending bit, and a 1 written at 0x88 clears the matching secondary pending bit. If the input is still high, the pending bit is set again, so clearing an asserted input leaves it pending. Reads of 0x10/0x14 and 0x88 return the raw pending bits.
- R4: A pending bit is captured on the clock edge after its input goes high, whether or not the source is enabled. It stays set after the input drops, until it is cleared.
- R5: The index register at 0x40 returns, in bits 5:0, the lowest number in 1..39 whose primary source is both pending and enabled. It returns 0 when there is no such source.
- R6: `irq_out` is high exactly when at least one primary source, including source 0, is both pending and enabled.
- R7: The secondary status register at 0x80 returns secondary pending AND secondary enable. Any nonzero status raises the level input of primary source 0, and primary pending bit 0 is set on the next clock edge.
- R8: The channel map word of source i is at 0x200 + 4*i and holds a 6-bit value. Reset loads i into it. Software writes replace it, and bits above bit 5 read as zero.
- R9: After reset, all enables and pending bits are zero. A read of any address not named above returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| addr | input | 12 | Byte address of the register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| src_pri | input | 40 | Primary level inputs; bit 0 is OR-ed with the cascade |
| src_sec | input | 32 | Secondary level inputs |
| irq_out | output | 1 | Request line to the CPU |

## Verification
The hardest condition to reach is the cascade. A secondary input must be captured, pass the secondary enable, and then be captured again as primary pending 0. The index register must still read 0 while `irq_out` is high. The bench gets there by enabling two secondary sources and primary 0 and then raising one enabled and one disabled secondary input. After two edges it compares the masked status, the raw pending bits, the index and `irq_out`. It then retires the request in the order software uses: clear the secondary source first, then primary 0.

// File: rtl/cascade_intc.sv
module cascade_intc #(
  parameter int NUM_PRI = 40,
  parameter int NUM_SEC = 32,
  parameter int AW      = 12,
  parameter int DW      = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  input  logic [NUM_PRI-1:0] src_pri,
  input  logic [NUM_SEC-1:0] src_sec,
  output logic               irq_out
);
  localparam int PB = (NUM_PRI + DW - 1) / DW;
  localparam int PW = PB * DW;
  localparam int IW = $clog2(NUM_PRI);

  localparam int OFS_CLR  = 'h10;
  localparam int OFS_SET  = 'h20;
  localparam int OFS_DIS  = 'h30;
  localparam int OFS_IDX  = 'h40;
  localparam int OFS_SST  = 'h80;
  localparam int OFS_SCLR = 'h88;
  localparam int OFS_SSET = 'h90;
  localparam int OFS_SDIS = 'h98;
  localparam int OFS_MAP  = 'h200;

  logic [NUM_PRI-1:0] pri_en, pri_pend, pri_act, pri_lvl;
  logic [NUM_SEC-1:0] sec_en, sec_pend, sec_act;
  logic [IW-1:0]      chmap [NUM_PRI];
  logic [IW-1:0]      idx;
  logic [PW-1:0]      m_clr, m_set, m_dis, pad_pend, pad_en;
  logic               cascade;

  assign sec_act  = sec_pend & sec_en;
  assign cascade  = |sec_act;
  assign pri_lvl  = src_pri | {{(NUM_PRI-1){1'b0}}, cascade};
  assign pri_act  = pri_pend & pri_en;
  assign irq_out  = |pri_act;
  assign pad_pend = PW'(pri_pend);
  assign pad_en   = PW'(pri_en);

  always_comb begin
    m_clr = '0;
    m_set = '0;
    m_dis = '0;
    for (int b = 0; b < PB; b++) begin
      if (wr_en && addr == AW'(OFS_CLR + 4*b)) m_clr[b*DW +: DW] = wr_data;
      if (wr_en && addr == AW'(OFS_SET + 4*b)) m_set[b*DW +: DW] = wr_data;
      if (wr_en && addr == AW'(OFS_DIS + 4*b)) m_dis[b*DW +: DW] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_en   <= '0;
      pri_pend <= '0;
      sec_en   <= '0;
      sec_pend <= '0;
    end else begin
      pri_pend <= (pri_pend & ~m_clr[NUM_PRI-1:0]) | pri_lvl;
      pri_en   <= (pri_en | m_set[NUM_PRI-1:0]) & ~m_dis[NUM_PRI-1:0];
      sec_pend <= (sec_pend & ~((wr_en && addr == AW'(OFS_SCLR)) ? wr_data[NUM_SEC-1:0] : '0))
                  | src_sec;
      sec_en   <= (sec_en | ((wr_en && addr == AW'(OFS_SSET)) ? wr_data[NUM_SEC-1:0] : '0))
                  & ~((wr_en && addr == AW'(OFS_SDIS)) ? wr_data[NUM_SEC-1:0] : '0);
    end
  end

  for (genvar i = 0; i < NUM_PRI; i++) begin : g_map
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   chmap[i] <= IW'(i);
      else if (wr_en && addr == AW'(OFS_MAP + 4*i)) chmap[i] <= wr_data[IW-1:0];
    end
  end

  always_comb begin
    idx = '0;
    for (int i = NUM_PRI-1; i >= 1; i--)
      if (pri_act[i]) idx = IW'(i);
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < PB; b++) begin
      if (addr == AW'(OFS_CLR + 4*b)) rd_data = pad_pend[b*DW +: DW];
      if (addr == AW'(OFS_SET + 4*b) || addr == AW'(OFS_DIS + 4*b))
        rd_data = pad_en[b*DW +: DW];
    end
    if (addr == AW'(OFS_IDX))  rd_data = DW'(idx);
    if (addr == AW'(OFS_SST))  rd_data = DW'(sec_act);
    if (addr == AW'(OFS_SCLR)) rd_data = DW'(sec_pend);
    if (addr == AW'(OFS_SSET) || addr == AW'(OFS_SDIS)) rd_data = DW'(sec_en);
    for (int i = 0; i < NUM_PRI; i++)
      if (addr == AW'(OFS_MAP + 4*i)) rd_data = DW'(chmap[i]);
  end
endmodule

// File: rtl/cascade_intc_chk.sv
module cascade_intc_chk #(
  parameter int NUM_PRI = 40,
  parameter int AW      = 12,
  parameter int DW      = 32,
  parameter int IW      = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [AW-1:0]      addr,
  input logic [DW-1:0]      wr_data,
  input logic [NUM_PRI-1:0] src_pri,
  input logic               irq_out,
  input logic [NUM_PRI-1:0] pri_en,
  input logic [NUM_PRI-1:0] pri_pend,
  input logic [IW-1:0]      idx
);
  a_r2_en_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h20)) |=> ((pri_en[DW-1:0] & $past(wr_data)) == $past(wr_data)));

  a_r2_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'('h30)) |=> ((pri_en[DW-1:0] & $past(wr_data)) == '0));

  a_r3_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
    src_pri[NUM_PRI-1] |=> pri_pend[NUM_PRI-1]);

  a_r5_idx_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_out |-> (idx == '0));

  a_r5_idx_active: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != '0) |-> (pri_en[idx] && pri_pend[idx] && irq_out));
endmodule

bind cascade_intc cascade_intc_chk #(
  .NUM_PRI(NUM_PRI), .AW(AW), .DW(DW), .IW(IW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .src_pri(src_pri), .irq_out(irq_out), .pri_en(pri_en), .pri_pend(pri_pend),
  .idx(idx)
);

// File: tb/test_cascade_intc.sv
module test_cascade_intc;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [39:0] src_pri = '0;
  logic [31:0] src_sec = '0;
  logic        irq_out;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cascade_intc i_cascade_intc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .src_pri(src_pri), .src_sec(src_sec), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a; wr_en = 0;
    #1 chk(req, rd_data, exp);
  endtask

  task automatic t_reset;
    rd_chk("R9 enable after reset", 12'h020, 0);
    rd_chk("R9 pending after reset", 12'h010, 0);
    rd_chk("R9 sec status after reset", 12'h080, 0);
    rd_chk("R5 index after reset", 12'h040, 0);
    chk("R6 irq after reset", {31'd0, irq_out}, 0);
    rd_chk("R8 map 39 identity", 12'h29C, 39);
    rd_chk("R8 map 0 identity", 12'h200, 0);
  endtask

  task automatic t_enable;
    wr(12'h020, 32'h0000_00F0);
    rd_chk("R2 enable set", 12'h020, 32'h0000_00F0);
    wr(12'h030, 32'h0000_0030);
    rd_chk("R2 enable clear", 12'h030, 32'h0000_00C0);
    wr(12'h020, 32'h0);
    rd_chk("R2 zero write no effect", 12'h020, 32'h0000_00C0);
    wr(12'h030, 32'hFFFF_FFFF);
    rd_chk("R2 clear all", 12'h020, 0);
  endtask

  task automatic t_bank;
    wr(12'h024, 32'hFFFF_FFFF);
    rd_chk("R1 bank1 width", 12'h024, 32'h0000_00FF);
    rd_chk("R1 bank0 untouched", 12'h020, 0);
    wr(12'h034, 32'h0000_00FF);
    rd_chk("R1 bank1 cleared", 12'h024, 0);
  endtask

  task automatic t_priority;
    wr(12'h020, 32'h0000_0220);
    wr(12'h024, 32'h0000_0002);
    @(negedge clk);
    src_pri[9] = 1; src_pri[33] = 1;
    step(1);
    rd_chk("R5 index lowest of 9,33", 12'h040, 9);
    chk("R6 irq with active primary", {31'd0, irq_out}, 1);
    src_pri[5] = 1;
    step(1);
    rd_chk("R5 index picks 5", 12'h040, 5);
    src_pri = '0;
    wr(12'h010, 32'h0000_0220);
    rd_chk("R5 index bank1 source", 12'h040, 33);
    wr(12'h014, 32'h0000_0002);
    rd_chk("R5 index idle", 12'h040, 0);
    chk("R6 irq idle", {31'd0, irq_out}, 0);
    wr(12'h030, 32'hFFFF_FFFF);
    wr(12'h034, 32'hFFFF_FFFF);
  endtask

  task automatic t_level;
    @(negedge clk);
    src_pri[12] = 1;
    step(1);
    rd_chk("R4 pending while disabled", 12'h010, 32'h0000_1000);
    chk("R6 masked source no irq", {31'd0, irq_out}, 0);
    rd_chk("R5 masked source no index", 12'h040, 0);
    wr(12'h010, 32'h0000_1000);
    rd_chk("R3 clear with input high re-asserts", 12'h010, 32'h0000_1000);
    src_pri[12] = 0;
    step(2);
    rd_chk("R4 pending latched after drop", 12'h010, 32'h0000_1000);
    wr(12'h010, 32'h0000_1000);
    rd_chk("R3 clear after drop", 12'h010, 0);
  endtask

  task automatic t_cascade;
    wr(12'h090, 32'h0000_0088);
    rd_chk("R2 secondary enable set", 12'h090, 32'h0000_0088);
    wr(12'h020, 32'h0000_0001);
    @(negedge clk);
    src_sec[7] = 1; src_sec[10] = 1;
    step(2);
    rd_chk("R7 secondary status masked", 12'h080, 32'h0000_0080);
    rd_chk("R3 secondary raw pending", 12'h088, 32'h0000_0480);
    rd_chk("R7 primary 0 pending", 12'h010, 32'h0000_0001);
    rd_chk("R5 index 0 on cascade", 12'h040, 0);
    chk("R7 irq from cascade", {31'd0, irq_out}, 1);
    src_sec = '0;
    wr(12'h088, 32'h0000_0480);
    rd_chk("R3 secondary cleared", 12'h088, 0);
    wr(12'h010, 32'h0000_0001);
    chk("R6 irq after cascade retired", {31'd0, irq_out}, 0);
    wr(12'h098, 32'h0000_0080);
    rd_chk("R2 secondary enable clear", 12'h098, 32'h0000_0008);
  endtask

  task automatic t_map;
    wr(12'h20C, 32'hFFFF_FF25);
    rd_chk("R8 map write 6 bits", 12'h20C, 32'h0000_0025);
    rd_chk("R8 neighbour unchanged", 12'h210, 4);
    rd_chk("R9 unimplemented 0x2A0", 12'h2A0, 0);
    rd_chk("R9 unimplemented 0x00C", 12'h00C, 0);
    rd_chk("R9 unimplemented 0x018", 12'h018, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    t_reset;
    t_enable;
    t_bank;
    t_priority;
    t_level;
    t_cascade;
    t_map;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule